// File: doc/BRIEF.md
# In-band XON/XOFF Flow Controller

This block automates software flow control for a serial port. On the receive side it compares the receive FIFO fill level with a pair of programmable thresholds. It asks the transmitter to insert an XOFF character when the FIFO gets full, and an XON character once the FIFO has drained again. Between the two thresholds no request is made, which gives the hysteresis. The transmitter takes the inserted character ahead of its next FIFO character. It acknowledges the take with a one-cycle strobe, and it never cuts into a character it is already shifting out.

On the transmit side the block watches every received character. A received XOFF character raises a pause level, which tells the transmitter to stop once its current character is done. A received XON character lowers that level again. When special-character detection is on, a received character equal to the second XOFF value sets a sticky flag. The interrupt logic reads this flag and clears it with a one-cycle strobe. Flow control runs only when both the enhanced-mode enable and the flow enable are high. Special-character detection needs the enhanced-mode enable and its own enable. All outputs are registered and change one clock after the inputs that cause them.

Top module: `inband_flow_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears ins_req, tx_pause and spc_flag, and clears the record of an outstanding XOFF.
- R2: With flow control active, no request pending and no XOFF outstanding, a level at or above hi_thr raises ins_req one cycle later with ins_char equal to xoff1_chr.
- R3: An XON request (ins_char equal to xon1_chr) is raised only while an accepted XOFF is outstanding, and only once the level is at or below the low threshold. Levels strictly between the thresholds raise nothing, so XOFF and XON always alternate.
- R4: A low threshold of 0x00 behaves exactly like 0x01.
- R5: A raised request holds ins_req and an unchanged ins_char until ins_ack is seen with it. The cycle after that acknowledge, ins_req is low.
- R6: With flow control active, a received character (rx_valid high) equal to xoff1_chr sets tx_pause on the next cycle. One equal to xon1_chr clears it. Any other character leaves it unchanged.
- R7: With enh_mode and spc_en high, a received character equal to xoff2_chr sets spc_flag on the next cycle. The flag stays set until a flag_clr pulse. If set and clear happen in the same cycle, the set wins.
- R8: When enh_mode or flow_en is low, ins_req and tx_pause drop on the next cycle and the outstanding-XOFF record is cleared. When enh_mode or spc_en is low, received characters do not set spc_flag.
- R9: An ins_ack with no request pending is ignored. It does not stop a request from being raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode | input | 1 | Enhanced-mode enable, gates all functions |
| flow_en | input | 1 | Automatic in-band flow control enable |
| spc_en | input | 1 | Special-character detection enable |
| rx_level | input | LVL_W | Current receive FIFO fill level |
| lo_thr | input | LVL_W | Low threshold (XON point) |
| hi_thr | input | LVL_W | High threshold (XOFF point) |
| xon1_chr | input | 8 | XON character |
| xoff1_chr | input | 8 | XOFF character |
| xoff2_chr | input | 8 | Special character to detect |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| ins_ack | input | 1 | Transmitter has taken the inserted character |
| flag_clr | input | 1 | Clears the special-character flag |
| ins_req | output | 1 | Request to insert a flow-control character |
| ins_char | output | 8 | Character to insert |
| tx_pause | output | 1 | Transmitter must pause after its current character |
| spc_flag | output | 1 | Sticky special-character match, interrupt source |

## Verification
The properties assume that the transmitter pulses ins_ack only for a single cycle per taken character. They also assume that the character registers are static while a comparison matters, and that the low threshold sits below the high threshold. The stimulus table keeps the thresholds at 64 and 100, or 0 and 100. It acknowledges each request in exactly one row, and it holds the XON, XOFF and special characters at fixed, distinct values. Every input changes half a period away from the sampling edge, so each row stands for exactly one clock of behaviour.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
  localparam int unsigned CHAR_W = 8;
  typedef logic [CHAR_W-1:0] char_t;

  // character comparison used by both receive-side watchers
  function automatic logic chr_hit(input logic strobe, input char_t got, input char_t ref_chr);
    return strobe && (got == ref_chr);
  endfunction
endpackage

// File: rtl/swfc_level_mon.sv
module swfc_level_mon
  import swfc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] lo_thr,
  input  logic [LVL_W-1:0] hi_thr,
  input  char_t            xon_chr,
  input  char_t            xoff_chr,
  input  logic             ins_ack,
  output logic             ins_req,
  output char_t            ins_char,
  output logic             xoff_outstanding,
  output logic             req_is_xoff
);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  // zero is not a legal low threshold; treat it as one
  function automatic logic [LVL_W-1:0] low_floor(input logic [LVL_W-1:0] thr);
    return (thr == '0) ? LVL_ONE : thr;
  endfunction

  function automatic logic full_enough(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] hi);
    return lvl >= hi;
  endfunction

  function automatic logic drained(input logic [LVL_W-1:0] lvl, input logic [LVL_W-1:0] lo);
    return lvl <= low_floor(lo);
  endfunction

  logic  req_q, is_xoff_q, sent_q;
  char_t chr_q;
  logic  want_xoff, want_xon, take;

  assign want_xoff = !sent_q && full_enough(rx_level, hi_thr);
  assign want_xon  =  sent_q && drained(rx_level, lo_thr);
  assign take      = req_q && ins_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      is_xoff_q <= 1'b0;
      sent_q    <= 1'b0;
      chr_q     <= '0;
    end else if (!active) begin
      req_q     <= 1'b0;
      is_xoff_q <= 1'b0;
      sent_q    <= 1'b0;
    end else if (take) begin
      req_q  <= 1'b0;
      sent_q <= is_xoff_q;
    end else if (!req_q && (want_xoff || want_xon)) begin
      req_q     <= 1'b1;
      is_xoff_q <= want_xoff;
      chr_q     <= want_xoff ? xoff_chr : xon_chr;
    end
  end

  assign ins_req          = req_q;
  assign ins_char         = chr_q;
  assign xoff_outstanding = sent_q;
  assign req_is_xoff      = is_xoff_q;
endmodule

// File: rtl/swfc_char_watch.sv
module swfc_char_watch
  import swfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flow_active,
  input  logic  spc_active,
  input  logic  rx_valid,
  input  char_t rx_char,
  input  char_t xon_chr,
  input  char_t xoff_chr,
  input  char_t spc_chr,
  input  logic  flag_clr,
  output logic  tx_pause,
  output logic  spc_flag
);
  logic hit_xoff, hit_xon, hit_spc;
  logic pause_q, flag_q;

  assign hit_xoff = flow_active && chr_hit(rx_valid, rx_char, xoff_chr);
  assign hit_xon  = flow_active && chr_hit(rx_valid, rx_char, xon_chr);
  assign hit_spc  = spc_active  && chr_hit(rx_valid, rx_char, spc_chr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pause_q <= 1'b0;
    else if (!flow_active) pause_q <= 1'b0;
    else if (hit_xoff)     pause_q <= 1'b1;
    else if (hit_xon)      pause_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (hit_spc)  flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign tx_pause = pause_q;
  assign spc_flag = flag_q;
endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl
  import swfc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_mode,
  input  logic             flow_en,
  input  logic             spc_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] lo_thr,
  input  logic [LVL_W-1:0] hi_thr,
  input  logic [7:0]       xon1_chr,
  input  logic [7:0]       xoff1_chr,
  input  logic [7:0]       xoff2_chr,
  input  logic             rx_valid,
  input  logic [7:0]       rx_char,
  input  logic             ins_ack,
  input  logic             flag_clr,
  output logic             ins_req,
  output logic [7:0]       ins_char,
  output logic             tx_pause,
  output logic             spc_flag
);
  logic flow_active, spc_active;
  logic xoff_outstanding, req_is_xoff;

  assign flow_active = enh_mode && flow_en;
  assign spc_active  = enh_mode && spc_en;

  swfc_level_mon #(.LVL_W(LVL_W)) u_level (
    .clk              (clk),
    .rst_n            (rst_n),
    .active           (flow_active),
    .rx_level         (rx_level),
    .lo_thr           (lo_thr),
    .hi_thr           (hi_thr),
    .xon_chr          (xon1_chr),
    .xoff_chr         (xoff1_chr),
    .ins_ack          (ins_ack),
    .ins_req          (ins_req),
    .ins_char         (ins_char),
    .xoff_outstanding (xoff_outstanding),
    .req_is_xoff      (req_is_xoff)
  );

  swfc_char_watch u_watch (
    .clk         (clk),
    .rst_n       (rst_n),
    .flow_active (flow_active),
    .spc_active  (spc_active),
    .rx_valid    (rx_valid),
    .rx_char     (rx_char),
    .xon_chr     (xon1_chr),
    .xoff_chr    (xoff1_chr),
    .spc_chr     (xoff2_chr),
    .flag_clr    (flag_clr),
    .tx_pause    (tx_pause),
    .spc_flag    (spc_flag)
  );
endmodule

// File: rtl/inband_flow_ctrl_chk.sv
module inband_flow_ctrl_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enh_mode,
  input logic       flow_en,
  input logic       spc_en,
  input logic [7:0] xoff1_chr,
  input logic [7:0] xoff2_chr,
  input logic       rx_valid,
  input logic [7:0] rx_char,
  input logic       ins_ack,
  input logic       ins_req,
  input logic [7:0] ins_char,
  input logic       tx_pause,
  input logic       spc_flag,
  input logic       xoff_outstanding,
  input logic       req_is_xoff
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !ins_ack && enh_mode && flow_en |=> ins_req && $stable(ins_char));

  assert_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && ins_ack |=> !ins_req);

  assert_xon_after_xoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req && !req_is_xoff |-> xoff_outstanding);

  assert_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && enh_mode && flow_en && rx_char == xoff1_chr |=> tx_pause);

  assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && enh_mode && spc_en && rx_char == xoff2_chr |=> spc_flag);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(enh_mode && flow_en) |=> !ins_req && !tx_pause && !xoff_outstanding);
endmodule

bind inband_flow_ctrl inband_flow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .enh_mode         (enh_mode),
  .flow_en          (flow_en),
  .spc_en           (spc_en),
  .xoff1_chr        (xoff1_chr),
  .xoff2_chr        (xoff2_chr),
  .rx_valid         (rx_valid),
  .rx_char          (rx_char),
  .ins_ack          (ins_ack),
  .ins_req          (ins_req),
  .ins_char         (ins_char),
  .tx_pause         (tx_pause),
  .spc_flag         (spc_flag),
  .xoff_outstanding (xoff_outstanding),
  .req_is_xoff      (req_is_xoff)
);

// File: tb/test_inband_flow_ctrl.sv
module test_inband_flow_ctrl;
  localparam int unsigned LVL_W = 8;
  localparam logic [7:0] XON  = 8'h11;
  localparam logic [7:0] XOFF = 8'h13;
  localparam logic [7:0] SPC  = 8'h93;
  localparam int NV = 30;

  typedef struct packed {
    logic [3:0] rq;
    logic       enh, flow, spc;
    logic [7:0] lvl, lo, hi;
    logic       rv;
    logic [7:0] rc;
    logic       ack, clr;
    logic       ereq;
    logic [7:0] echar;
    logic       epause, eflag;
  } vec_t;

  // each row: requirement, modes, level, lo, hi, rx_valid, rx_char, ack, clr | expected req, char, pause, flag
  localparam logic [52:0] VEC [NV] = '{
    {4'd2, 3'b111, 8'd10,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 low level
    {4'd2, 3'b111, 8'd99,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 one below
    {4'd2, 3'b111, 8'd100, 8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0}, // R2 at high
    {4'd5, 3'b111, 8'd100, 8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0}, // R5 held
    {4'd5, 3'b111, 8'd100, 8'd64, 8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 taken
    {4'd3, 3'b111, 8'd80,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 hysteresis
    {4'd3, 3'b111, 8'd64,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0}, // R3 XON at low
    {4'd5, 3'b111, 8'd64,  8'd64, 8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 taken
    {4'd3, 3'b111, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R3 no second XON
    {4'd6, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R6 XOFF pauses
    {4'd6, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R6 other char
    {4'd6, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 XON resumes
    {4'd7, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h93, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R7 match
    {4'd7, 3'b111, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}, // R7 sticky
    {4'd7, 3'b111, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R7 cleared
    {4'd7, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h93, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1}, // R7 set wins
    {4'd7, 3'b111, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0}, // R7 cleared
    {4'd8, 3'b110, 8'd30,  8'd64, 8'd100, 1'b1, 8'h93, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 detect off
    {4'd9, 3'b111, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R9 stray ack
    {4'd9, 3'b111, 8'd100, 8'd64, 8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0}, // R9 ack ignored
    {4'd5, 3'b111, 8'd100, 8'd64, 8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 taken
    {4'd8, 3'b011, 8'd10,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 no XON when off
    {4'd8, 3'b111, 8'd10,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R8 record cleared
    {4'd4, 3'b111, 8'd100, 8'd0,  8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h13, 1'b0, 1'b0}, // R4 XOFF
    {4'd5, 3'b111, 8'd100, 8'd0,  8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 taken
    {4'd4, 3'b111, 8'd2,   8'd0,  8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R4 level 2 not low
    {4'd4, 3'b111, 8'd1,   8'd0,  8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b0}, // R4 zero acts as one
    {4'd5, 3'b111, 8'd1,   8'd0,  8'd100, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 taken
    {4'd6, 3'b111, 8'd30,  8'd64, 8'd100, 1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R6 pause
    {4'd8, 3'b101, 8'd30,  8'd64, 8'd100, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0}  // R8 flow off drops pause
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_mode = 1'b0, flow_en = 1'b0, spc_en = 1'b0;
  logic [LVL_W-1:0] rx_level = '0, lo_thr = '0, hi_thr = '0;
  logic rx_valid = 1'b0, ins_ack = 1'b0, flag_clr = 1'b0;
  logic [7:0] rx_char = '0;
  logic ins_req, tx_pause, spc_flag;
  logic [7:0] ins_char;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  inband_flow_ctrl #(.LVL_W(LVL_W)) i_inband_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .flow_en(flow_en), .spc_en(spc_en),
    .rx_level(rx_level), .lo_thr(lo_thr), .hi_thr(hi_thr),
    .xon1_chr(XON), .xoff1_chr(XOFF), .xoff2_chr(SPC),
    .rx_valid(rx_valid), .rx_char(rx_char), .ins_ack(ins_ack), .flag_clr(flag_clr),
    .ins_req(ins_req), .ins_char(ins_char), .tx_pause(tx_pause), .spc_flag(spc_flag)
  );

  task automatic chk(input string rq, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "ins_req in reset", int'(ins_req), 0);
    chk("R1", "tx_pause in reset", int'(tx_pause), 0);
    chk("R1", "spc_flag in reset", int'(spc_flag), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d row %0d", v.rq, i);
      {enh_mode, flow_en, spc_en} = {v.enh, v.flow, v.spc};
      rx_level = v.lvl; lo_thr = v.lo; hi_thr = v.hi;
      rx_valid = v.rv; rx_char = v.rc; ins_ack = v.ack; flag_clr = v.clr;
      @(negedge clk);
      chk(tag, "ins_req", int'(ins_req), int'(v.ereq));
      if (v.ereq) chk(tag, "ins_char", int'(ins_char), int'(v.echar));
      chk(tag, "tx_pause", int'(tx_pause), int'(v.epause));
      chk(tag, "spc_flag", int'(spc_flag), int'(v.eflag));
    end

    // R1: reset in the middle of operation clears every output
    {enh_mode, flow_en, spc_en} = 3'b111;
    rx_level = 8'd100; lo_thr = 8'd64; hi_thr = 8'd100;
    ins_ack = 1'b0; flag_clr = 1'b0;
    rx_valid = 1'b1; rx_char = XOFF;
    @(negedge clk);
    rx_char = SPC;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R1", "pre-reset tx_pause", int'(tx_pause), 1);
    chk("R1", "pre-reset spc_flag", int'(spc_flag), 1);
    chk("R1", "pre-reset ins_req", int'(ins_req), 1);
    rst_n = 1'b0;
    #1;
    chk("R1", "ins_req after reset", int'(ins_req), 0);
    chk("R1", "tx_pause after reset", int'(tx_pause), 0);
    chk("R1", "spc_flag after reset", int'(spc_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
    rx_level = 8'd10;
    @(negedge clk);
    // R1: outstanding XOFF record was cleared, so a low level asks for nothing
    chk("R1", "no XON after reset", int'(ins_req), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule